// File: doc/BRIEF.md
# Programmable Down-Counting Event Timer

This block is a 64-bit down-counter behind a small word-addressed register port. Software writes a 64-bit start value as two 32-bit halves, then sets the enable bit in the control word. Each clock the count drops by one. When it has been observed at zero, the block latches a pending-event flag. That flag drives a level interrupt line when the event is unmasked. Software reads the live count back as two 32-bit halves.

There are two counting styles. The periodic style reloads the start value on the clock after zero and runs forever, so a start value of N-1 gives one event every N clocks. The single-shot style parks at zero after its one event and stays there until software clears the enable and sets it again. A build parameter picks one of two fixed byte offsets for the control word.

A three-state machine sequences the counter. `ST_IDLE` goes to `ST_RUN` when enable is seen, and loads the count. `ST_RUN` goes back to `ST_IDLE` when enable drops. `ST_RUN` goes to `ST_HOLD` at zero in single-shot style. `ST_HOLD` goes to `ST_IDLE` when enable drops. In periodic style `ST_RUN` stays in `ST_RUN` at zero and reloads.

Top module: `cdown_timer`

## Requirements
- R1: After reset, the control word, the pending flag, the count and both start-value halves read 0, and `irq` is low.
- R2: With `CTRL_ALT`=0 the control word sits at byte offset 0x10. With `CTRL_ALT`=1 it sits at 0x1C. Writes to the other of the two offsets are ignored, and reads there return 0, as they do at any unmapped offset.
- R3: The control word has three fields: bit 0 is enable, bit 1 is single-shot, and bit 2 is interrupt unmask. One clock after enable is first seen, the count equals {start high word at 0x04, start low word at 0x00}. It then drops by one on every clock while nonzero. The count is read at 0x08 (low word) and 0x0C (high word).
- R4: In periodic style (bit 1 = 0), the clock after the count is zero sets the pending flag and reloads the start value. Events therefore repeat every start+1 clocks.
- R5: In single-shot style (bit 1 = 1), the count stops at zero after one event and produces no further events. Clearing enable and then setting it again re-arms the counter from the start value.
- R6: Writing 0 to the control word stops the count within one clock, and the count then holds its value.
- R7: `irq` equals the pending flag when bit 2 is 1. It stays low when bit 2 is 0, even though the flag still sets.
- R8: The pending flag is bit 0 at offset 0x18. Writing 1 to that bit clears it. Writing 0 to that bit leaves it unchanged.
- R9: If a clear write and a new event fall on the same clock, the flag stays set.
- R10: Writes to the start-value words while enable is 1 are ignored.
- R11: The count is a true 64-bit value: a borrow out of the low word decrements the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, pending flag gated by unmask |

## Verification
If the state machine held a wrong state, the count read at 0x08 would disagree with the expected value on the very next read. Examples are staying in `ST_RUN` after a single-shot event, or loading on the wrong edge. The pending flag would also set one period early or late, or set a second time. Off-by-one errors in the reload or the arm step show as a period of N or N+2 clocks instead of N+1. A wrong priority between the clear write and an event shows the flag low in the cycle right after the collision. The bench reads the count and the flag on the cycles where each change is due, so any such defect shows within one or two clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // byte offsets of the register window
    localparam int OFF_START_LO = 'h00;
    localparam int OFF_START_HI = 'h04;
    localparam int OFF_COUNT_LO = 'h08;
    localparam int OFF_COUNT_HI = 'h0C;
    localparam int OFF_FLAG     = 'h18;
    localparam int OFF_CTRL_STD = 'h10;
    localparam int OFF_CTRL_ALT = 'h1C;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

    // field order is the control word bit order: [2] unmask, [1] single-shot, [0] enable
    typedef struct packed {
        logic unmask;
        logic one_shot;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int WORD_W   = 32,
    parameter bit CTRL_ALT = 1'b0,
    localparam int CNT_W   = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  start_val,
    output logic              clr_req,
    output logic [WORD_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = CTRL_ALT ? ADDR_W'(OFF_CTRL_ALT)
                                                    : ADDR_W'(OFF_CTRL_STD);
    localparam logic [ADDR_W-1:0] A_SLO  = ADDR_W'(OFF_START_LO);
    localparam logic [ADDR_W-1:0] A_SHI  = ADDR_W'(OFF_START_HI);
    localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(OFF_COUNT_LO);
    localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(OFF_COUNT_HI);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFF_FLAG);

    ctrl_t             ctrl_q;
    logic [WORD_W-1:0] start_lo_q;
    logic [WORD_W-1:0] start_hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            start_lo_q <= '0;
            start_hi_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL)
                ctrl_q <= ctrl_t'(wdata[2:0]);
            // start words are locked while the counter is enabled
            if (addr == A_SLO && !ctrl_q.en)
                start_lo_q <= wdata;
            if (addr == A_SHI && !ctrl_q.en)
                start_hi_q <= wdata;
        end
    end

    assign ctrl      = ctrl_q;
    assign start_val = {start_hi_q, start_lo_q};
    assign clr_req   = wr_en && (addr == A_FLAG) && wdata[0];

    always_comb begin
        rdata = '0;
        if (addr == A_SLO)       rdata = start_lo_q;
        else if (addr == A_SHI)  rdata = start_hi_q;
        else if (addr == A_CLO)  rdata = count[WORD_W-1:0];
        else if (addr == A_CHI)  rdata = count[CNT_W-1:WORD_W];
        else if (addr == A_FLAG) rdata = WORD_W'(flag);
        else if (addr == A_CTRL) rdata = WORD_W'(ctrl_q);
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             one_shot,
    input  logic [CNT_W-1:0] start_val,
    output logic [CNT_W-1:0] count,
    output logic             hit,
    output run_state_e       state
);

    run_state_e       state_q;
    run_state_e       state_d;
    logic [CNT_W-1:0] count_q;
    logic             at_zero;

    assign at_zero = (count_q == '0);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_RUN;
            ST_RUN: begin
                if (!en)                     state_d = ST_IDLE;
                else if (at_zero && one_shot) state_d = ST_HOLD;
            end
            ST_HOLD: if (!en) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs: counter datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (en) count_q <= start_val;
                ST_RUN: begin
                    if (en) begin
                        if (!at_zero)      count_q <= count_q - 1'b1;
                        else if (!one_shot) count_q <= start_val;
                    end
                end
                default: ;
            endcase
        end
    end

    assign hit   = (state_q == ST_RUN) && en && at_zero;
    assign count = count_q;
    assign state = state_q;

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    input  logic unmask,
    output logic flag,
    output logic irq
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (hit)     flag_q <= 1'b1;   // a new event outranks a clear
        else if (clr_req) flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & unmask;

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int WORD_W   = 32,
    parameter bit CTRL_ALT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * WORD_W;

    ctrl_t            ctrl_s;
    logic [CNT_W-1:0] start_s;
    logic [CNT_W-1:0] count_s;
    logic             clr_s;
    logic             hit_s;
    logic             flag_s;
    run_state_e       state_s;

    tmr_regs #(
        .ADDR_W  (ADDR_W),
        .WORD_W  (WORD_W),
        .CTRL_ALT(CTRL_ALT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .count    (count_s),
        .flag     (flag_s),
        .ctrl     (ctrl_s),
        .start_val(start_s),
        .clr_req  (clr_s),
        .rdata    (rdata)
    );

    tmr_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_s.en),
        .one_shot (ctrl_s.one_shot),
        .start_val(start_s),
        .count    (count_s),
        .hit      (hit_s),
        .state    (state_s)
    );

    tmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit_s),
        .clr_req(clr_s),
        .unmask (ctrl_s.unmask),
        .flag   (flag_s),
        .irq    (irq)
    );

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic              irq,
    input run_state_e        state,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  start_val,
    input logic              hit,
    input logic              flag,
    input logic              en,
    input logic              one_shot
);

    localparam logic [ADDR_W-1:0] A_SLO  = ADDR_W'(OFF_START_LO);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFF_FLAG);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && count != '0) |=> (count == $past(count) - 1'b1));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && !one_shot && count == '0) |=> (count == $past(start_val)));

    assert_hold_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (count == '0));

    assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !en) |=> $stable(count));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_FLAG && wdata[0] && !hit) |=> !flag);

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    assert_start_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && wr_en && addr == A_SLO) |=> $stable(start_val));

endmodule

bind cdown_timer tmr_checker #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .state    (state_s),
    .count    (count_s),
    .start_val(start_s),
    .hit      (hit_s),
    .flag     (flag_s),
    .en       (ctrl_s.en),
    .one_shot (ctrl_s.one_shot)
);

// File: tb/test_cdown_timer.sv
module test_cdown_timer;

    localparam int CLK_P = 10;

    localparam logic [4:0] A_SLO  = 5'h00;
    localparam logic [4:0] A_SHI  = 5'h04;
    localparam logic [4:0] A_CLO  = 5'h08;
    localparam logic [4:0] A_CHI  = 5'h0C;
    localparam logic [4:0] A_CTRL = 5'h10;
    localparam logic [4:0] A_OTH  = 5'h1C;
    localparam logic [4:0] A_FLAG = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        logic [4:0]  a;
        string       req;
    } item_t;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cdown_timer i_cdown_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    // monitor: compares each queued expectation shortly after its driving edge
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.a, act, it.exp);
            end
        end
    end

    // one task call = one clock
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string req);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        it.is_irq = 1'b0; it.exp = e; it.a = a; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic chk_irq(input bit e, input string req);
        item_t it;
        @(negedge clk);
        wr_en = 1'b0;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.a = addr; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // reset state
        rd(A_CTRL, 32'h0, "R1");
        rd(A_FLAG, 32'h0, "R1");
        rd(A_CLO,  32'h0, "R1");
        rd(A_SHI,  32'h0, "R1");
        chk_irq(1'b0, "R1");

        // the alternate control offset is not mapped by default
        wr(A_OTH, 32'h7);
        rd(A_CTRL, 32'h0, "R2");
        rd(A_OTH,  32'h0, "R2");
        rd(5'h14,  32'h0, "R2");

        // periodic, unmasked, start 3
        wr(A_SLO, 32'd3);
        wr(A_SHI, 32'd0);
        wr(A_CTRL, 32'h5);          // op0
        idle(1);                    // op1
        rd(A_CLO, 32'd3, "R3");     // op2: loaded
        rd(A_CLO, 32'd2, "R3");
        rd(A_CLO, 32'd1, "R3");
        rd(A_CLO, 32'd0, "R3");     // op5
        rd(A_FLAG, 32'd1, "R4");    // op6: first event
        chk_irq(1'b1, "R7");        // op7
        wr(A_FLAG, 32'd1);          // op8: clear
        rd(A_FLAG, 32'd0, "R8");    // op9
        rd(A_FLAG, 32'd1, "R4");    // op10: second event, 4 clocks later
        wr(A_CTRL, 32'h0);          // op11: stop
        rd(A_CLO, 32'd1, "R6");
        idle(3);
        rd(A_CLO, 32'd1, "R6");
        rd(A_FLAG, 32'd1, "R6");
        wr(A_FLAG, 32'd0);          // writing 0 keeps the flag
        rd(A_FLAG, 32'd1, "R8");
        wr(A_FLAG, 32'd1);

        // periodic, masked; clear collides with the event
        wr(A_CTRL, 32'h1);          // op0
        idle(4);                    // op1..op4
        wr(A_FLAG, 32'd1);          // op5: same clock as the event
        rd(A_FLAG, 32'd1, "R9");
        chk_irq(1'b0, "R7");
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'd1);
        rd(A_FLAG, 32'd0, "R8");

        // single-shot, unmasked, start 2
        wr(A_SLO, 32'd2);
        wr(A_CTRL, 32'h7);          // op0
        wr(A_SLO, 32'd9);           // op1: locked
        idle(3);                    // op2..op4
        rd(A_FLAG, 32'd1, "R5");    // op5
        chk_irq(1'b1, "R7");
        wr(A_FLAG, 32'd1);
        idle(5);
        rd(A_FLAG, 32'd0, "R5");
        rd(A_CLO, 32'd0, "R5");
        rd(A_SLO, 32'd2, "R10");
        wr(A_CTRL, 32'h0);          // re-arm sequence
        wr(A_CTRL, 32'h7);
        rd(A_CLO, 32'd0, "R5");
        rd(A_CLO, 32'd2, "R5");
        wr(A_CTRL, 32'h0);
        wr(A_FLAG, 32'd1);

        // 64-bit borrow, start 0x1_0000_0001, single-shot masked
        wr(A_SLO, 32'd1);
        wr(A_SHI, 32'd1);
        rd(A_SHI, 32'd1, "R11");
        wr(A_CTRL, 32'h3);          // op0
        idle(1);
        rd(A_CHI, 32'd1, "R11");
        rd(A_CLO, 32'd0, "R11");
        rd(A_CLO, 32'hFFFF_FFFF, "R11");
        rd(A_CHI, 32'd0, "R11");
        wr(A_CTRL, 32'h0);

        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule